// File: doc/BRIEF.md
# Register Width and Emulation Mode Controller

This block holds the processor mode that decides how wide the working registers are. It keeps an emulation flag, an accumulator-width flag (m) and an index-width flag (x), and from them drives the operand masks and shift amounts the datapath uses. It also owns the X, Y, stack, direct, data bank and program bank registers. Whenever the mode changes, it trims or pins these registers so they agree with the current widths.

A two-state machine tracks the mode. `ST_EMUL` is the 8-bit compatible mode and `ST_NATIVE` is the 16-bit mode. The transition `LEAVE` (from `ST_EMUL` to `ST_NATIVE`) happens when an exchange request arrives while the effective carry is 0. The transition `ENTER` (from `ST_NATIVE` to `ST_EMUL`) happens when an exchange request arrives while the effective carry is 1. In every other cycle the machine stays in its current state. Every exchange request moves the previous emulation flag into the carry bit.

Status reads are combinational. Status writes, register writes and exchange requests take effect at the rising clock edge.

Top module: `em_width_ctrl`

## Requirements
- R1: After reset the block is in emulation mode with m=1 and x=1. The status readout is 8'h30, so the decimal bit (3) and the interrupt-disable bit (2) are clear. X and Y are 0, S is 16'h01FF, and D, DB and PB are 0.
- R2: An exchange request sets the emulation flag to the carry (status bit 0) and loads the carry with the previous emulation flag. When the two values are already equal, nothing changes.
- R3: Entering emulation forces m=1 and x=1, forces the stack high byte to 8'h01, and clears the upper bytes of X and Y, all at the same clock edge.
- R4: While in emulation, a write to S keeps the high byte at 8'h01 and stores only the low byte.
- R5: A flag value of 1 means 8-bit. When x=1, the index mask is 16'h00FF and the index shift is 0. The upper bytes of X and Y are zero from the edge that sets x, and X and Y writes keep only the low byte. When x=0, the index mask is 16'hFFFF and the index shift is 8.
- R6: When m=1, the accumulator keep mask is 16'hFF00 (the preserved high byte) and the accumulator shift is 0. When m=0, the keep mask is 16'h0000 and the shift is 8.
- R7: In native mode, the status readout shows m in bit 5 and x in bit 4, with the stored byte in the other bits. In emulation mode, the stored byte is returned unchanged.
- R8: A status write always stores the byte. In native mode it also loads m from bit 5 and x from bit 4. In emulation mode, m and x are left unchanged.
- R9: When a status write and an exchange request fall in the same cycle, the exchange uses the carry from the written byte. The stored bit 0 then becomes the previous emulation flag.
- R10: The register write select uses this encoding: 0=X, 1=Y, 2=S, 3=D, 4=DB, 5=PB. D takes 16 bits of data; DB and PB take the low 8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stat_wr_en | input | 1 | Status byte write strobe |
| stat_wr_data | input | 8 | Status byte to write |
| stat_rd_data | output | 8 | Status byte readout |
| xchg_req | input | 1 | Exchange carry with emulation flag |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 3 | Register select (0=X,1=Y,2=S,3=D,4=DB,5=PB) |
| reg_wr_data | input | 16 | Register write data |
| emu_mode | output | 1 | 1 in emulation mode |
| mem_8bit | output | 1 | m flag |
| idx_8bit | output | 1 | x flag |
| acc_keep_mask | output | 16 | Accumulator bits preserved by 8-bit operations |
| idx_mask | output | 16 | Index operand mask |
| acc_shift | output | 4 | Accumulator high-byte shift amount |
| idx_shift | output | 4 | Index high-byte shift amount |
| x_reg | output | 16 | X register |
| y_reg | output | 16 | Y register |
| s_reg | output | 16 | Stack pointer |
| d_reg | output | 16 | Direct register |
| db_reg | output | 8 | Data bank register |
| pb_reg | output | 8 | Program bank register |

## Verification
Two collisions matter, because each pairs a mode change with a register update in the same cycle. In the first, a status write and an exchange request fall in one cycle. The bench writes a byte with carry clear together with an exchange while in emulation. It then checks that the machine leaves emulation and that the readout shows the old emulation flag in bit 0. In the second, a width change meets register contents. The bench sets x or enters emulation and then checks X, Y and S at the ports on the very next cycle. It expects the upper bytes to be trimmed or pinned, and it expects later writes to keep being masked.

// File: rtl/em_pkg.sv
package em_pkg;
    typedef enum logic {
        ST_EMUL   = 1'b0,
        ST_NATIVE = 1'b1
    } em_state_e;

    typedef enum logic [2:0] {
        SEL_X  = 3'd0,
        SEL_Y  = 3'd1,
        SEL_S  = 3'd2,
        SEL_D  = 3'd3,
        SEL_DB = 3'd4,
        SEL_PB = 3'd5
    } em_sel_e;
endpackage

// File: rtl/em_mode_fsm.sv
module em_mode_fsm
    import em_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic xchg_req,
    input  logic carry_eff,
    output logic emu_q,
    output logic emu_next
);
    em_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMUL;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMUL:   if (xchg_req && !carry_eff) state_d = ST_NATIVE; // LEAVE
            ST_NATIVE: if (xchg_req &&  carry_eff) state_d = ST_EMUL;   // ENTER
            default:   state_d = ST_EMUL;
        endcase
    end

    always_comb begin
        emu_q    = (state_q == ST_EMUL);
        emu_next = (state_d == ST_EMUL);
    end
endmodule

// File: rtl/em_status.sv
module em_status #(
    parameter int BYTE_W  = 8,
    parameter int M_BIT   = 5,
    parameter int X_BIT   = 4,
    parameter logic [BYTE_W-1:0] RST_BYTE = 8'h30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              xchg_req,
    input  logic              emu_q,
    input  logic              emu_next,
    output logic              carry_eff,
    output logic              m_q,
    output logic              x_q,
    output logic              x_next,
    output logic [BYTE_W-1:0] rd_data
);
    logic [BYTE_W-1:0] p_q, p_d;
    logic              m_d;

    always_comb begin
        p_d       = wr_en ? wr_data : p_q;
        carry_eff = p_d[0];
        if (xchg_req) p_d[0] = emu_q;
        m_d    = m_q;
        x_next = x_q;
        if (wr_en && !emu_q) begin
            m_d    = wr_data[M_BIT];
            x_next = wr_data[X_BIT];
        end
        if (emu_next) begin
            m_d    = 1'b1;
            x_next = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_q <= RST_BYTE;
            m_q <= 1'b1;
            x_q <= 1'b1;
        end else begin
            p_q <= p_d;
            m_q <= m_d;
            x_q <= x_next;
        end
    end

    always_comb begin
        rd_data = p_q;
        if (!emu_q) begin
            rd_data[M_BIT] = m_q;
            rd_data[X_BIT] = x_q;
        end
    end
endmodule

// File: rtl/em_regfile.sv
module em_regfile
    import em_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8,
    parameter logic [BYTE_W-1:0] STACK_PAGE = 8'h01,
    parameter logic [BYTE_W-1:0] STACK_RST_LO = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              idx8_next,
    input  logic              emu_next,
    output logic [DATA_W-1:0] x_q,
    output logic [DATA_W-1:0] y_q,
    output logic [DATA_W-1:0] s_q,
    output logic [DATA_W-1:0] d_q,
    output logic [BYTE_W-1:0] db_q,
    output logic [BYTE_W-1:0] pb_q
);
    localparam int HI_W = DATA_W - BYTE_W;

    logic [DATA_W-1:0] x_w, y_w, s_w;

    always_comb begin
        x_w = (wr_en && wr_sel == SEL_X) ? wr_data : x_q;
        y_w = (wr_en && wr_sel == SEL_Y) ? wr_data : y_q;
        s_w = (wr_en && wr_sel == SEL_S) ? wr_data : s_q;
        if (idx8_next) begin
            x_w[DATA_W-1:BYTE_W] = '0;
            y_w[DATA_W-1:BYTE_W] = '0;
        end
        if (emu_next) s_w[DATA_W-1:BYTE_W] = HI_W'(STACK_PAGE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q  <= '0;
            y_q  <= '0;
            s_q  <= {HI_W'(STACK_PAGE), STACK_RST_LO};
            d_q  <= '0;
            db_q <= '0;
            pb_q <= '0;
        end else begin
            x_q <= x_w;
            y_q <= y_w;
            s_q <= s_w;
            if (wr_en && wr_sel == SEL_D)  d_q  <= wr_data;
            if (wr_en && wr_sel == SEL_DB) db_q <= wr_data[BYTE_W-1:0];
            if (wr_en && wr_sel == SEL_PB) pb_q <= wr_data[BYTE_W-1:0];
        end
    end
endmodule

// File: rtl/em_width_ctrl.sv
module em_width_ctrl
    import em_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8,
    parameter int SHW    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stat_wr_en,
    input  logic [BYTE_W-1:0] stat_wr_data,
    output logic [BYTE_W-1:0] stat_rd_data,
    input  logic              xchg_req,
    input  logic              reg_wr_en,
    input  logic [2:0]        reg_wr_sel,
    input  logic [DATA_W-1:0] reg_wr_data,
    output logic              emu_mode,
    output logic              mem_8bit,
    output logic              idx_8bit,
    output logic [DATA_W-1:0] acc_keep_mask,
    output logic [DATA_W-1:0] idx_mask,
    output logic [SHW-1:0]    acc_shift,
    output logic [SHW-1:0]    idx_shift,
    output logic [DATA_W-1:0] x_reg,
    output logic [DATA_W-1:0] y_reg,
    output logic [DATA_W-1:0] s_reg,
    output logic [DATA_W-1:0] d_reg,
    output logic [BYTE_W-1:0] db_reg,
    output logic [BYTE_W-1:0] pb_reg
);
    localparam int HI_W = DATA_W - BYTE_W;
    localparam logic [DATA_W-1:0] LO_ONES = {{HI_W{1'b0}}, {BYTE_W{1'b1}}};

    logic carry_eff, emu_next, x_next;

    em_mode_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .xchg_req  (xchg_req),
        .carry_eff (carry_eff),
        .emu_q     (emu_mode),
        .emu_next  (emu_next)
    );

    em_status #(.BYTE_W(BYTE_W)) u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (stat_wr_en),
        .wr_data   (stat_wr_data),
        .xchg_req  (xchg_req),
        .emu_q     (emu_mode),
        .emu_next  (emu_next),
        .carry_eff (carry_eff),
        .m_q       (mem_8bit),
        .x_q       (idx_8bit),
        .x_next    (x_next),
        .rd_data   (stat_rd_data)
    );

    em_regfile #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr_en),
        .wr_sel    (reg_wr_sel),
        .wr_data   (reg_wr_data),
        .idx8_next (x_next),
        .emu_next  (emu_next),
        .x_q       (x_reg),
        .y_q       (y_reg),
        .s_q       (s_reg),
        .d_q       (d_reg),
        .db_q      (db_reg),
        .pb_q      (pb_reg)
    );

    always_comb begin
        acc_keep_mask = mem_8bit ? ~LO_ONES : '0;
        idx_mask      = idx_8bit ? LO_ONES : '1;
        acc_shift     = mem_8bit ? '0 : SHW'(BYTE_W);
        idx_shift     = idx_8bit ? '0 : SHW'(BYTE_W);
    end
endmodule

// File: rtl/em_width_ctrl_chk.sv
module em_width_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        stat_wr_en,
    input logic        xchg_req,
    input logic [7:0]  stat_rd_data,
    input logic        emu_mode,
    input logic        mem_8bit,
    input logic        idx_8bit,
    input logic [15:0] x_reg,
    input logic [15:0] y_reg,
    input logic [15:0] s_reg
);
    // R3: entry into emulation forces both widths to 8-bit
    a_r3_enter_forces: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(emu_mode) |-> (mem_8bit && idx_8bit && s_reg[15:8] == 8'h01));

    // R4: stack stays on page one while emulating
    a_r4_stack_page: assert property (@(posedge clk) disable iff (!rst_n)
        emu_mode |-> (s_reg[15:8] == 8'h01));

    // R5: 8-bit index width leaves no upper bits in X or Y
    a_r5_idx_trunc: assert property (@(posedge clk) disable iff (!rst_n)
        idx_8bit |-> (x_reg[15:8] == 8'h00 && y_reg[15:8] == 8'h00));

    // R8: status write in emulation leaves the width flags alone
    a_r8_emu_write_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (emu_mode && stat_wr_en && !xchg_req) |=> ($stable(mem_8bit) && $stable(idx_8bit)));

    // R2: exchange with carry equal to the mode is a no-op
    a_r2_noop_xchg: assert property (@(posedge clk) disable iff (!rst_n)
        (xchg_req && !stat_wr_en && stat_rd_data[0] == emu_mode)
        |=> ($stable(emu_mode) && $stable(stat_rd_data)));
endmodule

bind em_width_ctrl em_width_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .stat_wr_en   (stat_wr_en),
    .xchg_req     (xchg_req),
    .stat_rd_data (stat_rd_data),
    .emu_mode     (emu_mode),
    .mem_8bit     (mem_8bit),
    .idx_8bit     (idx_8bit),
    .x_reg        (x_reg),
    .y_reg        (y_reg),
    .s_reg        (s_reg)
);

// File: tb/em_width_ctrl_tb.sv
module em_width_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stat_wr_en = 1'b0;
    logic [7:0]  stat_wr_data = '0;
    logic [7:0]  stat_rd_data;
    logic        xchg_req = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [2:0]  reg_wr_sel = '0;
    logic [15:0] reg_wr_data = '0;
    logic        emu_mode, mem_8bit, idx_8bit;
    logic [15:0] acc_keep_mask, idx_mask, x_reg, y_reg, s_reg, d_reg;
    logic [3:0]  acc_shift, idx_shift;
    logic [7:0]  db_reg, pb_reg;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    em_width_ctrl u_dut (.*);

    // {swe, swd[8], xchg, rwe, sel[3], rwd[16], e_stat[8], e_x[16], e_s[16], e_emu}
    localparam int NV = 16;
    localparam logic [70:0] VEC [NV] = '{
        {1'b1, 8'h00, 1'b0, 1'b0, 3'd0, 16'h0000, 8'h00, 16'h0000, 16'h01FF, 1'b1},
        {1'b0, 8'h00, 1'b1, 1'b0, 3'd0, 16'h0000, 8'h31, 16'h0000, 16'h01FF, 1'b0},
        {1'b0, 8'h00, 1'b0, 1'b1, 3'd0, 16'hABCD, 8'h31, 16'h00CD, 16'h01FF, 1'b0},
        {1'b1, 8'h00, 1'b0, 1'b0, 3'd0, 16'h0000, 8'h00, 16'h00CD, 16'h01FF, 1'b0},
        {1'b0, 8'h00, 1'b0, 1'b1, 3'd0, 16'hABCD, 8'h00, 16'hABCD, 16'h01FF, 1'b0},
        {1'b0, 8'h00, 1'b0, 1'b1, 3'd2, 16'h1234, 8'h00, 16'hABCD, 16'h1234, 1'b0},
        {1'b1, 8'h10, 1'b0, 1'b0, 3'd0, 16'h0000, 8'h10, 16'h00CD, 16'h1234, 1'b0},
        {1'b1, 8'h00, 1'b0, 1'b0, 3'd0, 16'h0000, 8'h00, 16'h00CD, 16'h1234, 1'b0},
        {1'b0, 8'h00, 1'b0, 1'b1, 3'd0, 16'hBEEF, 8'h00, 16'hBEEF, 16'h1234, 1'b0},
        {1'b0, 8'h00, 1'b1, 1'b0, 3'd0, 16'h0000, 8'h00, 16'hBEEF, 16'h1234, 1'b0},
        {1'b1, 8'h01, 1'b0, 1'b0, 3'd0, 16'h0000, 8'h01, 16'hBEEF, 16'h1234, 1'b0},
        {1'b0, 8'h00, 1'b1, 1'b0, 3'd0, 16'h0000, 8'h00, 16'h00EF, 16'h0134, 1'b1},
        {1'b0, 8'h00, 1'b0, 1'b1, 3'd2, 16'h5678, 8'h00, 16'h00EF, 16'h0178, 1'b1},
        {1'b1, 8'h01, 1'b0, 1'b0, 3'd0, 16'h0000, 8'h01, 16'h00EF, 16'h0178, 1'b1},
        {1'b0, 8'h00, 1'b1, 1'b0, 3'd0, 16'h0000, 8'h01, 16'h00EF, 16'h0178, 1'b1},
        {1'b1, 8'hC0, 1'b1, 1'b0, 3'd0, 16'h0000, 8'hF1, 16'h00EF, 16'h0178, 1'b0}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        stat_wr_en = 1'b0;
        xchg_req   = 1'b0;
        reg_wr_en  = 1'b0;
    endtask

    task automatic swr(input logic [7:0] v);
        stat_wr_en = 1'b1; stat_wr_data = v; step();
    endtask

    task automatic rwr(input logic [2:0] sel, input logic [15:0] v);
        reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = v; step();
    endtask

    task automatic xchg();
        xchg_req = 1'b1; step();
    endtask

    task automatic check_reset(input string tag);
        chk({tag, " R1 emu"}, 16'(emu_mode), 16'h1);
        chk({tag, " R1 stat"}, 16'(stat_rd_data), 16'h0030);
        chk({tag, " R1 x"}, x_reg, 16'h0000);
        chk({tag, " R1 y"}, y_reg, 16'h0000);
        chk({tag, " R1 s"}, s_reg, 16'h01FF);
        chk({tag, " R1 d"}, d_reg, 16'h0000);
        chk({tag, " R1 db"}, 16'(db_reg), 16'h0000);
        chk({tag, " R1 pb"}, 16'(pb_reg), 16'h0000);
        chk({tag, " R1 flags"}, {14'd0, mem_8bit, idx_8bit}, 16'h3);
    endtask

    initial begin
        #200000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_reset("init");
        chk("R6 keep", acc_keep_mask, 16'hFF00);
        chk("R5 idxmask", idx_mask, 16'h00FF);

        // Table walk: R2 R3 R4 R5 R7 R8 R9
        for (int i = 0; i < NV; i++) begin
            stat_wr_en   = VEC[i][70];
            stat_wr_data = VEC[i][69:62];
            xchg_req     = VEC[i][61];
            reg_wr_en    = VEC[i][60];
            reg_wr_sel   = VEC[i][59:57];
            reg_wr_data  = VEC[i][56:41];
            step();
            chk($sformatf("vec%0d R7 stat", i), 16'(stat_rd_data), 16'(VEC[i][40:33]));
            chk($sformatf("vec%0d R5 x", i), x_reg, VEC[i][32:17]);
            chk($sformatf("vec%0d R4 s", i), s_reg, VEC[i][16:1]);
            chk($sformatf("vec%0d R2 emu", i), 16'(emu_mode), 16'(VEC[i][0]));
        end

        // Now native, m=1 x=1. R6/R5 widths.
        swr(8'h20);
        chk("R6 keep m1", acc_keep_mask, 16'hFF00);
        chk("R6 shift m1", 16'(acc_shift), 16'd0);
        chk("R5 mask x0", idx_mask, 16'hFFFF);
        chk("R5 shift x0", 16'(idx_shift), 16'd8);
        swr(8'h10);
        chk("R6 keep m0", acc_keep_mask, 16'h0000);
        chk("R6 shift m0", 16'(acc_shift), 16'd8);
        chk("R5 mask x1", idx_mask, 16'h00FF);
        chk("R5 shift x1", 16'(idx_shift), 16'd0);

        // R5: Y truncated on the edge that sets x
        swr(8'h00);
        rwr(3'd1, 16'h1234);
        chk("R5 y full", y_reg, 16'h1234);
        swr(8'h10);
        chk("R5 y trunc", y_reg, 16'h0034);

        // R3: entering emulation clears Y high and forces m
        swr(8'h00);
        rwr(3'd1, 16'hABCD);
        swr(8'h01);
        xchg();
        chk("R3 emu", 16'(emu_mode), 16'h1);
        chk("R3 y", y_reg, 16'h00CD);
        chk("R3 m", {15'd0, mem_8bit}, 16'h1);
        chk("R3 s", s_reg[15:8], 16'h0001);

        // R8: emulation write with bits 5/4 clear; flags unchanged, raw byte read (R7)
        swr(8'h00);
        chk("R8 m", {14'd0, mem_8bit, idx_8bit}, 16'h3);
        chk("R7 raw", 16'(stat_rd_data), 16'h0000);

        // R10: D, DB, PB
        rwr(3'd3, 16'hC3A5);
        rwr(3'd4, 16'h1177);
        rwr(3'd5, 16'h2288);
        chk("R10 d", d_reg, 16'hC3A5);
        chk("R10 db", 16'(db_reg), 16'h0077);
        chk("R10 pb", 16'(pb_reg), 16'h0088);

        // R1: reset re-applied after activity
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        check_reset("rerun");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule